// File: doc/BRIEF.md
# LEB128 Streaming Value Codec

This block turns little-endian base-128 variable-length numbers into 32-bit words, and turns 32-bit words back into them. It has two independent halves. The decoder takes one byte per cycle from a bytecode stream and assembles the value. The encoder takes one word and sends it out as the shortest byte sequence on a valid/ready byte port.

The decoder keeps a count of the bytes it has taken for the current value. It uses that count to steer each 7-bit group into a fixed slot of an accumulator. When a byte with a clear continuation bit arrives, it presents the value with a one-cycle strobe and a tag marking it as an integer or a float bit pattern. A fifth byte that still asks for more, or that carries bits past bit 31, ends the value with an error strobe instead.

The encoder drops leading groups that carry no information, so the number of bytes depends on the value. A build parameter selects signed (two's-complement) handling for integer values in both halves. Float bit patterns are always handled as unsigned.

Top module: `leb_codec`

## Requirements
- R1: Each byte holds a continuation flag in bit 7 and payload in bits 6:0. The k-th byte of a value (k from 0) supplies bits 7k+6:7k of the result, so the lowest group comes first. With unsigned handling, bits the sequence does not reach are zero.
- R2: The cycle after an accepted byte with bit 7 clear, `dec_done` is high for one cycle and `dec_value` holds the assembled value. For example, the bytes AF 8A 01 give 17711.
- R3: The byte accepted right after a final byte starts a new value, with no idle cycle needed between values.
- R4: Cycles with `in_valid` low change no decoder state. A value whose bytes are spread out with gaps decodes the same as one sent without gaps.
- R5: If the fifth byte of a value has bit 7 set, or carries payload that does not fit in 32 bits, `dec_err` is high for one cycle in the next cycle and `dec_done` stays low. With unsigned handling, payload bits 6:4 of that byte must be zero. The next byte then starts a new value.
- R6: `dec_is_float` shows the `in_is_float` level sampled with the first byte of the value. Float values are never sign-extended.
- R7: With SIGNED=1, an integer value whose final byte has bit 6 set, and which has fewer than five bytes, is filled with ones above its last group. A fifth byte must have payload bits 6:4 equal to bit 3. For example, a single 7F decodes to FFFFFFFF.
- R8: `enc_ready` is high only while the encoder is idle. A word is taken when `enc_valid` and `enc_ready` are both high, and its first byte is offered in the next cycle.
- R9: With unsigned handling, the encoder sends bytes until the rest of the word is zero. Bit 7 is set on every byte except the last. For example, 0 gives 00, 122 gives 7A, and 963412 gives D4 E6 3A. No word needs more than five bytes.
- R10: With SIGNED=1 and an integer word, the encoder stops at the first group where the arithmetic rest of the word is all copies of that group's bit 6. For example, FFFFFFC0 gives the single byte 40, and 64 gives C0 00. Float words use the unsigned rule.
- R11: While `out_valid` is high and `out_ready` is low, `out_byte` holds steady. Each handshake moves to the next byte. After the handshake of the last byte, the encoder is idle in the next cycle.
- R12: During and right after reset, `dec_done`, `dec_err` and `out_valid` are low and `enc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoder byte present this cycle |
| in_byte | input | 8 | Decoder input byte |
| in_is_float | input | 1 | Value type, sampled with the first byte |
| dec_done | output | 1 | One-cycle strobe: value complete |
| dec_value | output | DATA_W | Decoded value |
| dec_is_float | output | 1 | Type tag of the decoded value |
| dec_err | output | 1 | One-cycle strobe: over-long or oversized sequence |
| enc_valid | input | 1 | Word offered to the encoder |
| enc_word | input | DATA_W | Word to encode |
| enc_is_float | input | 1 | Word is a float bit pattern (unsigned rule) |
| enc_ready | output | 1 | Encoder idle, can take a word |
| out_valid | output | 1 | Encoded byte offered |
| out_byte | output | 8 | Encoded byte |
| out_ready | input | 1 | Downstream takes the byte |

## Verification
The bound assertions check the strobe and handshake rules on every cycle. Completion and error never coincide, and each follows an accepted byte of the right kind. The output byte holds under backpressure, an accepted word produces a byte in the next cycle, a final byte returns the encoder to idle, and no word runs past five bytes. The bench covers what only whole scenarios can show. These are the decoded values and their sign filling, the tag that follows the first byte, the exact shortest byte sequences in both modes, recovery after an error, and gaps in the input. The bench runs an unsigned and a signed instance side by side, against a behavioural model that is checked on every clock.

// File: rtl/leb_pkg.sv
package leb_pkg;
    localparam int LEB_GRP_W = 7;
    localparam int LEB_FLAG  = 7;

    typedef enum logic {
        ENC_IDLE,
        ENC_EMIT
    } enc_mode_e;

    function automatic int leb_groups(input int width);
        return (width + LEB_GRP_W - 1) / LEB_GRP_W;
    endfunction
endpackage

// File: rtl/leb_demux.sv
module leb_demux
    import leb_pkg::*;
#(
    parameter int NB    = 5,
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0]        sel,
    input  logic [LEB_GRP_W-1:0]    grp,
    output logic [NB*LEB_GRP_W-1:0] placed
);
    // one fixed slot per byte position; the counter picks which slot is written
    for (genvar g = 0; g < NB; g++) begin : g_slot
        assign placed[g*LEB_GRP_W +: LEB_GRP_W] = (sel == CNT_W'(g)) ? grp : '0;
    end
endmodule

// File: rtl/leb_decoder.sv
module leb_decoder
    import leb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter bit SIGNED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              in_is_float,
    output logic              dec_done,
    output logic [DATA_W-1:0] dec_value,
    output logic              dec_is_float,
    output logic              dec_err
);
    localparam int NB        = leb_groups(DATA_W);
    localparam int ACC_W     = NB * LEB_GRP_W;
    localparam int CNT_W     = $clog2(NB + 1);
    localparam int LAST_USED = DATA_W - LEB_GRP_W * (NB - 1);
    localparam logic [LEB_GRP_W-1:0] HI_MASK = LEB_GRP_W'(7'h7F << LAST_USED);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [ACC_W-1:0]  acc;
        logic              flt;
        logic              done;
        logic              err;
        logic [DATA_W-1:0] val;
        logic              vflt;
    } dec_st_t;

    dec_st_t s_d, s_q;

    logic [ACC_W-1:0]     placed;
    logic [ACC_W-1:0]     acc_new;
    logic [ACC_W-1:0]     ext;
    logic [LEB_GRP_W-1:0] hi_bits;
    logic                 flt_cur;
    logic                 sgn_int;
    logic                 last_slot;
    logic                 oversize;
    logic                 bad;

    leb_demux #(.NB(NB), .CNT_W(CNT_W)) u_demux (
        .sel    (s_q.cnt),
        .grp    (in_byte[LEB_GRP_W-1:0]),
        .placed (placed)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.err   = 1'b0;
        acc_new   = s_q.acc | placed;
        flt_cur   = (s_q.cnt == '0) ? in_is_float : s_q.flt;
        sgn_int   = SIGNED && !flt_cur;
        last_slot = (s_q.cnt == CNT_W'(NB - 1));
        hi_bits   = in_byte[LEB_GRP_W-1:0] & HI_MASK;
        if (sgn_int && in_byte[LAST_USED-1]) begin
            oversize = (hi_bits != HI_MASK);
        end else begin
            oversize = (hi_bits != '0);
        end
        bad = last_slot && (in_byte[LEB_FLAG] || oversize);
        ext = acc_new;
        if (sgn_int && in_byte[LEB_GRP_W-1] && !last_slot) begin
            ext = acc_new | ({ACC_W{1'b1}} << (LEB_GRP_W * (int'(s_q.cnt) + 1)));
        end
        if (in_valid) begin
            if (bad) begin
                s_d.err = 1'b1;
                s_d.cnt = '0;
                s_d.acc = '0;
            end else if (!in_byte[LEB_FLAG]) begin
                s_d.done = 1'b1;
                s_d.val  = ext[DATA_W-1:0];
                s_d.vflt = flt_cur;
                s_d.cnt  = '0;
                s_d.acc  = '0;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
                s_d.acc = acc_new;
                s_d.flt = flt_cur;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dec_done     = s_q.done;
    assign dec_err      = s_q.err;
    assign dec_value    = s_q.val;
    assign dec_is_float = s_q.vflt;
endmodule

// File: rtl/leb_encoder.sv
module leb_encoder
    import leb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter bit SIGNED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_valid,
    input  logic [DATA_W-1:0] enc_word,
    input  logic              enc_is_float,
    output logic              enc_ready,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    input  logic              out_ready
);
    typedef struct packed {
        enc_mode_e         mode;
        logic [DATA_W-1:0] word;
        logic              sgn;
    } enc_st_t;

    enc_st_t s_d, s_q;

    logic signed [DATA_W-1:0] w_s;
    logic signed [DATA_W-1:0] rest_a;
    logic        [DATA_W-1:0] rest_l;
    logic        [DATA_W-1:0] rest;
    logic                     more;

    always_comb begin
        w_s    = s_q.word;
        rest_a = w_s >>> LEB_GRP_W;
        rest_l = s_q.word >> LEB_GRP_W;
        rest   = s_q.sgn ? rest_a : rest_l;
        if (s_q.sgn) begin
            more = !(((rest == '0) && !s_q.word[LEB_GRP_W-1]) ||
                     ((&rest) && s_q.word[LEB_GRP_W-1]));
        end else begin
            more = |rest;
        end

        s_d = s_q;
        case (s_q.mode)
            ENC_IDLE: begin
                if (enc_valid) begin
                    s_d.mode = ENC_EMIT;
                    s_d.word = enc_word;
                    s_d.sgn  = SIGNED && !enc_is_float;
                end
            end
            ENC_EMIT: begin
                if (out_ready) begin
                    if (more) begin
                        s_d.word = rest;
                    end else begin
                        s_d.mode = ENC_IDLE;
                    end
                end
            end
            default: s_d.mode = ENC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{mode: ENC_IDLE, word: '0, sgn: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign enc_ready = (s_q.mode == ENC_IDLE);
    assign out_valid = (s_q.mode == ENC_EMIT);
    assign out_byte  = {more, s_q.word[LEB_GRP_W-1:0]};
endmodule

// File: rtl/leb_codec.sv
module leb_codec
    import leb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter bit SIGNED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              in_is_float,
    output logic              dec_done,
    output logic [DATA_W-1:0] dec_value,
    output logic              dec_is_float,
    output logic              dec_err,
    input  logic              enc_valid,
    input  logic [DATA_W-1:0] enc_word,
    input  logic              enc_is_float,
    output logic              enc_ready,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    input  logic              out_ready
);
    leb_decoder #(.DATA_W(DATA_W), .SIGNED(SIGNED)) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .in_is_float  (in_is_float),
        .dec_done     (dec_done),
        .dec_value    (dec_value),
        .dec_is_float (dec_is_float),
        .dec_err      (dec_err)
    );

    leb_encoder #(.DATA_W(DATA_W), .SIGNED(SIGNED)) u_enc (
        .clk          (clk),
        .rst_n        (rst_n),
        .enc_valid    (enc_valid),
        .enc_word     (enc_word),
        .enc_is_float (enc_is_float),
        .enc_ready    (enc_ready),
        .out_valid    (out_valid),
        .out_byte     (out_byte),
        .out_ready    (out_ready)
    );
endmodule

// File: rtl/leb_codec_chk.sv
module leb_codec_chk
    import leb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [7:0]        in_byte,
    input logic              dec_done,
    input logic              dec_err,
    input logic              enc_valid,
    input logic              enc_ready,
    input logic              out_valid,
    input logic [7:0]        out_byte,
    input logic              out_ready
);
    localparam int NB   = leb_groups(DATA_W);
    localparam int CN_W = $clog2(NB + 2);

    logic [CN_W-1:0] sent_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_q <= '0;
        end else if (out_valid && out_ready) begin
            sent_q <= out_byte[LEB_FLAG] ? sent_q + CN_W'(1) : '0;
        end
    end

    // R2: completion only after an accepted final byte
    a_r2_done_after_final: assert property (@(posedge clk) disable iff (!rst_n)
        dec_done |-> ($past(in_valid) && !$past(in_byte[7])));

    // R5: error only after an accepted byte, never with completion
    a_r5_err_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> ($past(in_valid) && !dec_done));

    // R8: accepted word offers a byte next cycle
    a_r8_accept_emits: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_valid && enc_ready) |=> out_valid);

    // R11: byte held under backpressure
    a_r11_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

    // R11: last byte returns to idle
    a_r11_last_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_byte[7]) |=> (!out_valid && enc_ready));

    // R9: at most NB bytes per word
    a_r9_byte_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |-> (sent_q < CN_W'(NB)));
endmodule

bind leb_codec leb_codec_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .dec_done  (dec_done),
    .dec_err   (dec_err),
    .enc_valid (enc_valid),
    .enc_ready (enc_ready),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .out_ready (out_ready)
);

// File: tb/sim_leb_codec.sv
`timescale 1ns/1ps
module sim_leb_codec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_is_float = 1'b0;
    logic        enc_valid = 1'b0;
    logic [31:0] enc_word = 32'h0;
    logic        enc_is_float = 1'b0;
    logic        out_ready = 1'b1;
    bit          bp_on = 1'b0;

    logic [1:0]  dd, de, df, er, ov;
    logic [31:0] dv [2];
    logic [7:0]  ob [2];

    int checks = 0;
    int fails = 0;
    bit reported = 1'b0;

    // behavioural model state, index 0 unsigned, 1 signed
    int          m_cnt [2];
    longint      m_acc [2];
    bit          m_flt [2];
    bit          e_done [2];
    bit          e_err [2];
    logic [31:0] e_val [2];
    bit          e_flt [2];
    logic [7:0]  eq [2][$];
    logic [7:0]  cap [2][$];

    always #2 clk = ~clk;

    leb_codec #(.DATA_W(32), .SIGNED(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_is_float(in_is_float), .dec_done(dd[0]), .dec_value(dv[0]),
        .dec_is_float(df[0]), .dec_err(de[0]), .enc_valid(enc_valid),
        .enc_word(enc_word), .enc_is_float(enc_is_float), .enc_ready(er[0]),
        .out_valid(ov[0]), .out_byte(ob[0]), .out_ready(out_ready)
    );

    leb_codec #(.DATA_W(32), .SIGNED(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_is_float(in_is_float), .dec_done(dd[1]), .dec_value(dv[1]),
        .dec_is_float(df[1]), .dec_err(de[1]), .enc_valid(enc_valid),
        .enc_word(enc_word), .enc_is_float(enc_is_float), .enc_ready(er[1]),
        .out_valid(ov[1]), .out_byte(ob[1]), .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    function automatic void enc_model(input int i, input logic [31:0] w, input bit fl);
        longint v;
        longint b;
        bit stop;
        v = (i == 1 && !fl) ? longint'($signed(w)) : longint'({32'd0, w});
        for (int k = 0; k < 6; k++) begin
            b = v & 127;
            v = v >>> 7;
            if (i == 1 && !fl) stop = (v == 0 && (b & 64) == 0) || (v == -1 && (b & 64) != 0);
            else stop = (v == 0);
            eq[i].push_back(stop ? 8'(b) : 8'(b | 128));
            if (stop) break;
        end
    endfunction

    function automatic void dec_model(input int i);
        bit f;
        bit si;
        bit bad;
        longint acc;
        longint v;
        f = (m_cnt[i] == 0) ? in_is_float : m_flt[i];
        si = (i == 1) && !f;
        acc = m_acc[i] | (longint'(in_byte & 8'h7F) << (7 * m_cnt[i]));
        bad = 1'b0;
        if (m_cnt[i] == 4) begin
            if (in_byte[7]) bad = 1'b1;
            else if (si) bad = !(((acc >> 31) == 0) || ((acc >> 31) == 15));
            else bad = ((acc >> 32) != 0);
        end
        if (bad) begin
            e_err[i] = 1'b1;
            m_cnt[i] = 0;
            m_acc[i] = 0;
        end else if (!in_byte[7]) begin
            v = acc;
            if (si && in_byte[6] && m_cnt[i] < 4) v = acc | (longint'(-1) << (7 * (m_cnt[i] + 1)));
            e_done[i] = 1'b1;
            e_val[i] = v[31:0];
            e_flt[i] = f;
            m_cnt[i] = 0;
            m_acc[i] = 0;
        end else begin
            m_cnt[i] = m_cnt[i] + 1;
            m_acc[i] = acc;
            m_flt[i] = f;
        end
    endfunction

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 2; i++) begin
                chk(dd[i] == e_done[i], "R2", $sformatf("u%0d dec_done", i), dd[i], e_done[i]);
                chk(de[i] == e_err[i], "R5", $sformatf("u%0d dec_err", i), de[i], e_err[i]);
                if (e_done[i]) begin
                    chk(dv[i] == e_val[i], (i == 1) ? "R7" : "R1", $sformatf("u%0d dec_value", i), dv[i], e_val[i]);
                    chk(df[i] == e_flt[i], "R6", $sformatf("u%0d dec_is_float", i), df[i], e_flt[i]);
                end
                chk(ov[i] == (eq[i].size() != 0), "R11", $sformatf("u%0d out_valid", i), ov[i], eq[i].size() != 0);
                chk(er[i] == (eq[i].size() == 0), "R8", $sformatf("u%0d enc_ready", i), er[i], eq[i].size() == 0);
                if (eq[i].size() != 0) begin
                    chk(ob[i] == eq[i][0], (i == 1) ? "R10" : "R9", $sformatf("u%0d out_byte", i), ob[i], eq[i][0]);
                    if (ov[i] && out_ready) begin
                        cap[i].push_back(ob[i]);
                        void'(eq[i].pop_front());
                    end
                end else if (enc_valid && er[i]) begin
                    enc_model(i, enc_word, enc_is_float);
                end
                e_done[i] = 1'b0;
                e_err[i] = 1'b0;
                if (in_valid) dec_model(i);
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #1;
            out_ready = bp_on ? 1'($urandom % 2) : 1'b1;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=0 exp=1");
        report();
    end

    task automatic put(input logic [7:0] b, input bit f);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_byte = b;
        in_is_float = f;
    endtask

    task automatic gap();
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic put_word(input logic [31:0] w, input bit f);
        logic [31:0] v;
        v = w;
        for (int k = 0; k < 5; k++) begin
            put({(v >> 7) != 0, v[6:0]}, f);
            v = v >> 7;
            if (v == 0) break;
        end
    endtask

    task automatic wait_idle();
        do begin
            @(posedge clk);
            #1;
        end while (!(er[0] && er[1]));
    endtask

    task automatic send(input logic [31:0] w, input bit f);
        wait_idle();
        enc_valid = 1'b1;
        enc_word = w;
        enc_is_float = f;
        @(posedge clk);
        #1;
        enc_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_cnt[i] = 0; m_acc[i] = 0; m_flt[i] = 0;
            e_done[i] = 0; e_err[i] = 0; e_val[i] = 0; e_flt[i] = 0;
        end
        repeat (4) @(posedge clk);
        #1;
        for (int i = 0; i < 2; i++) begin
            chk(dd[i] == 0 && de[i] == 0, "R12", $sformatf("u%0d strobes in reset", i), {dd[i], de[i]}, 0);
            chk(ov[i] == 0 && er[i] == 1, "R12", $sformatf("u%0d encoder in reset", i), {ov[i], er[i]}, 1);
        end
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(dd == 0 && de == 0 && ov == 0 && er == 2'b11, "R12", "state after reset", {dd, de, ov, er}, 3);

        // R2: stated example
        put(8'hAF, 0); put(8'h8A, 0); put(8'h01, 0); gap();
        chk(dd[0] && dv[0] == 32'd17711, "R2", "AF 8A 01", dv[0], 17711);
        // R4: same bytes with gaps
        put(8'hAF, 0); gap(); gap(); put(8'h8A, 0); gap(); put(8'h01, 0); gap();
        chk(dd[0] && dv[0] == 32'd17711, "R4", "gapped AF 8A 01", dv[0], 17711);
        // R3: back-to-back
        put(8'h7A, 0); put(8'h05, 0); gap();
        chk(dd[0] && dv[0] == 32'd5, "R3", "back-to-back second value", dv[0], 5);
        // R7: sign fill
        put(8'h7F, 0); gap();
        chk(dd[1] && dv[1] == 32'hFFFFFFFF, "R7", "signed 7F", dv[1], 32'hFFFFFFFF);
        chk(dd[0] && dv[0] == 32'd127, "R1", "unsigned 7F", dv[0], 127);
        put(8'h40, 0); put(8'hFF, 0); put(8'hFF, 0); put(8'hFF, 0); put(8'hFF, 0); put(8'h0F, 0); gap();
        chk(dd[0] && dv[0] == 32'hFFFFFFFF, "R1", "unsigned maximum", dv[0], 32'hFFFFFFFF);
        chk(de[1] == 1'b1, "R7", "signed fifth byte 0F rejected", de[1], 1);
        put(8'hFF, 0); put(8'hFF, 0); put(8'hFF, 0); put(8'hFF, 0); put(8'h7F, 0); gap();
        chk(de[0] == 1'b1, "R5", "unsigned fifth byte 7F rejected", de[0], 1);
        chk(dd[1] && dv[1] == 32'hFFFFFFFF, "R7", "signed five-byte -1", dv[1], 32'hFFFFFFFF);
        put(8'h80, 0); put(8'h80, 0); put(8'h80, 0); put(8'h80, 0); put(8'h80, 0); gap();
        chk(de == 2'b11 && dd == 2'b00, "R5", "fifth byte continues", {de, dd}, 12);
        put(8'h03, 0); gap();
        chk(dd[0] && dv[0] == 32'd3, "R5", "recovery after error", dv[0], 3);
        // R6: float tag, no sign fill
        put_word(32'hBF800000, 1); gap();
        chk(df == 2'b11 && dv[1] == 32'hBF800000, "R6", "float tag and bits", dv[1], 32'hBF800000);
        put_word(32'hBF800000, 0); gap();
        chk(de[1] == 1'b1, "R7", "same bytes as signed integer", de[1], 1);
        put(8'hC0, 1); put(8'h00, 0); gap();
        chk(df[1] == 1'b1 && dv[1] == 32'd64, "R6", "tag from first byte", dv[1], 64);

        // encoder stated examples
        cap[0].delete(); cap[1].delete();
        send(32'd0, 0); wait_idle();
        chk(cap[0].size() == 1 && cap[0][0] == 8'h00, "R9", "zero is one byte", cap[0].size(), 1);
        cap[0].delete(); cap[1].delete();
        send(32'd122, 0); wait_idle();
        chk(cap[0].size() == 1 && cap[0][0] == 8'h7A, "R9", "122 encoding", cap[0][0], 8'h7A);
        chk(cap[1].size() == 2, "R10", "signed 122 needs two bytes", cap[1].size(), 2);
        cap[0].delete(); cap[1].delete();
        send(32'd963412, 0); wait_idle();
        chk(cap[0].size() == 3 && cap[0][0] == 8'hD4 && cap[0][1] == 8'hE6 && cap[0][2] == 8'h3A,
            "R9", "963412 encoding", cap[0].size(), 3);
        cap[0].delete(); cap[1].delete();
        send(32'hFFFFFFC0, 0); wait_idle();
        chk(cap[1].size() == 1 && cap[1][0] == 8'h40, "R10", "signed -64", cap[1][0], 8'h40);
        chk(cap[0].size() == 5, "R9", "unsigned FFFFFFC0 length", cap[0].size(), 5);
        cap[0].delete(); cap[1].delete();
        send(32'hBF800000, 1); wait_idle();
        chk(cap[1].size() == 5, "R10", "float word unsigned rule", cap[1].size(), 5);
        send(32'd64, 0); send(32'h80000000, 0);

        // backpressure and mixed traffic
        bp_on = 1'b1;
        for (int n = 0; n < 150; n++) begin
            logic [31:0] w;
            w = $urandom;
            if (n % 3 == 0) w = w >> (n % 31);
            send(w, 1'($urandom % 2));
            put_word(w, 1'($urandom % 2));
            gap();
        end
        wait_idle();
        bp_on = 1'b0;
        repeat (4) @(posedge clk);
        report();
    end
endmodule